// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits on the receive side of an Ethernet MAC, between the PHY-facing byte stream and the logic that stores frames. It takes one byte per cycle, qualified by a valid strobe. A start-of-frame flag marks the first byte, and an end-of-frame flag marks the last one. The block walks the preamble up to the start-frame delimiter. It then counts the frame bytes that follow, captures the Length/Type field, and compares the declared length against what actually arrived.

Four static configuration inputs control the checks:

- a pure-preamble check on the preamble content,
- a long-preamble limit,
- a length check,
- a huge-frame enable that turns off the oversize check.

CRC is computed elsewhere. The result comes in on a single `crc_ok` bit, which is sampled with the last byte.

One cycle after the last byte of each frame, the block pulses `stat_valid` and updates a status word. The status word holds error flags and the received frame length. A `drop` strobe rises in the same cycle for frames that must be discarded, which are frames with a bad or missing preamble/delimiter. Length and oversize problems are only reported in the status word and do not discard the frame.

Top module: `eth_rx_frame_check`

## Requirements
- R1: While reset is asserted, and directly after it, `stat_valid`, `drop` and `stat_word` are all zero.
- R2: `stat_valid` pulses for exactly one cycle, in the cycle after an accepted byte that carries `rx_eof`.
  - At that point `stat_word[22:7]` holds the frame length. The frame length counts the bytes after the 0xD5 delimiter, up to and including the last byte (FCS included).
  - `stat_word` keeps its value until the next frame ends.
- R3: With `cfg_pure_pre` set, bit 1 of the status word is set and `drop` pulses in either of these cases:
  - a preamble byte is not 0x55;
  - `rx_err` is high on any preamble byte or on the delimiter byte.

  With `cfg_pure_pre` clear, bit 1 is never set.
- R4: The preamble count is the number of bytes before the 0xD5 delimiter, not counting the delimiter. With `cfg_long_pre` set, a count of 12 or more sets bit 2 and drops the frame. A count of 11 is accepted. With `cfg_long_pre` clear, any count is accepted.
- R5: A frame that ends before any 0xD5 delimiter sets bit 5 and is dropped, whatever the configuration.
- R6: With `cfg_len_chk` set and a Length/Type value of 1500 or less, the payload count is compared with that value. The payload count is the frame length minus 18. The compared value is raised to 46 when it is smaller, to allow for padding. A mismatch sets bit 3 without dropping the frame. With `cfg_len_chk` clear, bit 3 is never set.
- R7: The Length/Type value is the frame bytes at positions 12 (high) and 13 (low). A value above 1500 sets bit 6, marking a type, and never produces a length mismatch.
- R8: Without `cfg_huge`, a frame length above `MAX_FRAME` sets bit 4 without dropping the frame. `MAX_FRAME` defaults to 1518. With `cfg_huge` set, bit 4 is never set.
- R9: Bit 0 of the status word is the inverse of `crc_ok`, sampled with the last byte.
- R10: The following are all ignored:
  - bytes with `rx_valid` low;
  - bytes outside a frame, including a stray `rx_eof`.

  A new `rx_sof` restarts the frame and discards all state gathered so far.
- R11: With `cfg_len_chk` set, a frame of fewer than 18 bytes after the delimiter always sets bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid this cycle |
| rx_sof | input | 1 | First byte of a frame (first preamble byte) |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | PHY error flag for this byte |
| rx_data | input | 8 | Received byte |
| crc_ok | input | 1 | External CRC result, sampled with the last byte |
| cfg_pure_pre | input | 1 | Enable preamble content checking |
| cfg_long_pre | input | 1 | Enable the preamble length limit |
| cfg_len_chk | input | 1 | Enable the Length/Type versus payload check |
| cfg_huge | input | 1 | Accept frames of any length without an oversize flag |
| stat_valid | output | 1 | One-cycle pulse when `stat_word` is updated |
| drop | output | 1 | One-cycle discard strobe, aligned with `stat_valid` |
| stat_word | output | LEN_W+7 | `{frame_length, type, no_sfd, oversize, len_mismatch, long_pre, bad_pre, crc_err}` |

## Verification
The bench builds the block with `MAX_FRAME` lowered to 128 and all other parameters at their defaults. This puts both sides of the oversize boundary (frame lengths of 128 and 129) within a frame of about 140 bytes. The Length/Type boundary at 1500/1501 and the preamble limit at 11/12 bytes are reached with short frames, because the type/length decision depends only on the field value and not on the frame length. Frames with idle gaps, stray bytes, restarted frames, missing delimiters and frames shorter than the header are driven directly.

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check #(
  parameter int LEN_W     = 16,
  parameter int MAX_PRE   = 12,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_LT    = 1500,
  parameter int MIN_PAY   = 46,
  parameter logic [7:0] PRE_BYTE = 8'h55,
  parameter logic [7:0] SFD_BYTE = 8'hD5,
  localparam int PW     = $clog2(MAX_PRE + 1),
  localparam int STAT_W = LEN_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  input  logic              crc_ok,
  input  logic              cfg_pure_pre,
  input  logic              cfg_long_pre,
  input  logic              cfg_len_chk,
  input  logic              cfg_huge,
  output logic              stat_valid,
  output logic              drop,
  output logic [STAT_W-1:0] stat_word
);

  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(14);
  localparam logic [LEN_W-1:0] OVH_LEN = LEN_W'(18);
  localparam logic [LEN_W-1:0] BIG_LEN = LEN_W'(MAX_FRAME);

  logic             in_pre, in_body, pre_bad;
  logic [PW-1:0]    pre_cnt;
  logic [LEN_W-1:0] flen;
  logic [15:0]      lt;

  logic sof, pre_byte, body_byte, is_sfd, eof;
  assign sof       = rx_valid && rx_sof;
  assign pre_byte  = rx_valid && (rx_sof || in_pre);
  assign body_byte = rx_valid && !rx_sof && in_body;
  assign is_sfd    = pre_byte && (rx_data == SFD_BYTE);
  assign eof       = rx_valid && rx_eof && (rx_sof || in_pre || in_body);

  logic [PW-1:0]    cnt_b, n_pre_cnt;
  logic             bad_b, n_pre_bad, n_pre, n_body;
  logic [LEN_W-1:0] n_flen;
  logic [15:0]      n_lt;

  assign cnt_b     = sof ? '0 : pre_cnt;
  assign bad_b     = sof ? 1'b0 : pre_bad;
  assign n_pre_cnt = (pre_byte && !is_sfd && cnt_b != PW'(MAX_PRE)) ? cnt_b + 1'b1 : cnt_b;
  assign n_pre_bad = pre_byte ? (bad_b || rx_err || (!is_sfd && rx_data != PRE_BYTE)) : pre_bad;
  assign n_pre     = sof ? !is_sfd : (in_pre && !is_sfd);
  assign n_body    = sof ? is_sfd : (in_body || is_sfd);
  assign n_flen    = sof ? '0 : ((body_byte && !(&flen)) ? flen + 1'b1 : flen);

  always_comb begin
    n_lt = sof ? 16'h0 : lt;
    if (body_byte && flen == LEN_W'(12)) n_lt[15:8] = rx_data;
    if (body_byte && flen == LEN_W'(13)) n_lt[7:0]  = rx_data;
  end

  logic [LEN_W-1:0] pay, exp_pay;
  logic f_type, f_len, f_over, f_pure, f_long, f_nosfd;
  assign pay     = n_flen - OVH_LEN;
  assign exp_pay = (n_lt < 16'(MIN_PAY)) ? LEN_W'(MIN_PAY) : LEN_W'(n_lt);
  assign f_type  = n_body && (n_flen >= HDR_LEN) && (n_lt > 16'(MAX_LT));
  assign f_len   = cfg_len_chk && n_body && !f_type && ((n_flen < OVH_LEN) || (pay != exp_pay));
  assign f_over  = !cfg_huge && (n_flen > BIG_LEN);
  assign f_pure  = cfg_pure_pre && n_pre_bad;
  assign f_long  = cfg_long_pre && (n_pre_cnt >= PW'(MAX_PRE));
  assign f_nosfd = !n_body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pre     <= 1'b0;
      in_body    <= 1'b0;
      pre_bad    <= 1'b0;
      pre_cnt    <= '0;
      flen       <= '0;
      lt         <= '0;
      stat_valid <= 1'b0;
      drop       <= 1'b0;
      stat_word  <= '0;
    end else begin
      in_pre     <= eof ? 1'b0 : n_pre;
      in_body    <= eof ? 1'b0 : n_body;
      pre_bad    <= n_pre_bad;
      pre_cnt    <= n_pre_cnt;
      flen       <= n_flen;
      lt         <= n_lt;
      stat_valid <= eof;
      drop       <= eof && (f_pure || f_long || f_nosfd);
      if (eof)
        stat_word <= {n_flen, f_type, f_nosfd, f_over, f_len, f_long, f_pure, !crc_ok};
    end
  end

endmodule

// File: rtl/eth_rx_frame_check_sva.sv
module eth_rx_frame_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_eof,
  input logic       crc_ok,
  input logic       cfg_pure_pre,
  input logic       cfg_long_pre,
  input logic       cfg_len_chk,
  input logic       cfg_huge,
  input logic       stat_valid,
  input logic       drop,
  input logic [6:0] flags
);

  assert_status_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(rx_valid && rx_eof));

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eof) |=> $stable(flags));

  assert_drop_needs_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> stat_valid);

  assert_pure_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !$past(cfg_pure_pre)) |-> !flags[1]);

  assert_long_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !$past(cfg_long_pre)) |-> !flags[2]);

  assert_nosfd_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && flags[5]) |-> drop);

  assert_len_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !$past(cfg_len_chk)) |-> !flags[3]);

  assert_type_no_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && flags[6]) |-> !flags[3]);

  assert_huge_no_oversize_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && $past(cfg_huge)) |-> !flags[4]);

  assert_crc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (flags[0] == !$past(crc_ok)));

endmodule

bind eth_rx_frame_check eth_rx_frame_check_sva i_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof), .crc_ok(crc_ok),
  .cfg_pure_pre(cfg_pure_pre), .cfg_long_pre(cfg_long_pre), .cfg_len_chk(cfg_len_chk),
  .cfg_huge(cfg_huge), .stat_valid(stat_valid), .drop(drop), .flags(stat_word[6:0])
);

// File: tb/test_eth_rx_frame_check.sv
`timescale 1ns/1ps
module test_eth_rx_frame_check;

  localparam int STAT_W = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0, crc_ok = 1;
  logic [7:0] rx_data = 8'h00;
  logic cfg_pure_pre = 0, cfg_long_pre = 0, cfg_len_chk = 0, cfg_huge = 0;
  logic stat_valid, drop;
  logic [STAT_W-1:0] stat_word;

  always #4 clk = ~clk;

  eth_rx_frame_check #(.MAX_FRAME(128)) i_eth_rx_frame_check (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_err(rx_err), .rx_data(rx_data), .crc_ok(crc_ok), .cfg_pure_pre(cfg_pure_pre),
    .cfg_long_pre(cfg_long_pre), .cfg_len_chk(cfg_len_chk), .cfg_huge(cfg_huge),
    .stat_valid(stat_valid), .drop(drop), .stat_word(stat_word)
  );

  typedef struct packed {
    logic [3:0]  cfg;     // {pure, long, len, huge}
    logic [7:0]  pre_n;
    logic        bad;
    logic [15:0] lt;
    logic [15:0] pay;
    logic        crc;
    logic [6:0]  flags;   // {type, nosfd, over, len, long, pure, crc_err}
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'b1110, 8'd7,  1'b0, 16'd46,    16'd46,  1'b1, 7'b0000000}, // R6 exact
    '{4'b1110, 8'd7,  1'b0, 16'd20,    16'd46,  1'b1, 7'b0000000}, // R6 padded
    '{4'b1110, 8'd7,  1'b0, 16'd50,    16'd46,  1'b1, 7'b0001000}, // R6 mismatch
    '{4'b1110, 8'd7,  1'b0, 16'h0800,  16'd46,  1'b1, 7'b1000000}, // R7 type
    '{4'b1110, 8'd7,  1'b0, 16'd1500,  16'd46,  1'b1, 7'b0001000}, // R6 edge length
    '{4'b1110, 8'd7,  1'b0, 16'd1501,  16'd46,  1'b1, 7'b1000000}, // R7 edge type
    '{4'b1110, 8'd7,  1'b0, 16'd46,    16'd46,  1'b0, 7'b0000001}, // R9
    '{4'b1110, 8'd7,  1'b1, 16'd46,    16'd46,  1'b1, 7'b0000010}, // R3
    '{4'b0110, 8'd7,  1'b1, 16'd46,    16'd46,  1'b1, 7'b0000000}, // R3 off
    '{4'b1110, 8'd11, 1'b0, 16'd46,    16'd46,  1'b1, 7'b0000000}, // R4 11 ok
    '{4'b1110, 8'd12, 1'b0, 16'd46,    16'd46,  1'b1, 7'b0000100}, // R4 12 long
    '{4'b1010, 8'd12, 1'b0, 16'd46,    16'd46,  1'b1, 7'b0000000}, // R4 off
    '{4'b1110, 8'd7,  1'b0, 16'd46,    16'd120, 1'b1, 7'b0011000}, // R8 over + R6
    '{4'b1111, 8'd7,  1'b0, 16'd120,   16'd120, 1'b1, 7'b0000000}, // R8 huge
    '{4'b1100, 8'd7,  1'b0, 16'd50,    16'd46,  1'b1, 7'b0000000}, // R6 off
    '{4'b1110, 8'd0,  1'b0, 16'd46,    16'd46,  1'b1, 7'b0000000}, // R4 zero preamble
    '{4'b1110, 8'd7,  1'b0, 16'd47,    16'd46,  1'b1, 7'b0001000}, // R6 above min
    '{4'b1110, 8'd7,  1'b0, 16'd110,   16'd110, 1'b1, 7'b0000000}, // R8 at limit
    '{4'b1110, 8'd7,  1'b0, 16'd111,   16'd111, 1'b1, 7'b0010000}  // R8 just over
  };

  int checks = 0, fails = 0;
  logic got_sv, got_drop;
  logic [STAT_W-1:0] got_stat;

  function automatic string req_of(input logic [6:0] f);
    if (f[1]) return "R3";
    if (f[2]) return "R4";
    if (f[4]) return "R8";
    if (f[3]) return "R6";
    if (f[6]) return "R7";
    if (f[0]) return "R9";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input bit s, input bit e, input bit er, input bit g);
    if (g) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = 8'hD5;
    end
    @(negedge clk);
    rx_valid = 1; rx_sof = s; rx_eof = e; rx_err = er; rx_data = d;
  endtask

  task automatic send(input logic [3:0] c, input int pre_n, input bit bad, input bit err_sfd,
                      input bit nosfd, input logic [15:0] lt, input int body_n,
                      input bit crc, input bit g);
    {cfg_pure_pre, cfg_long_pre, cfg_len_chk, cfg_huge} = c;
    crc_ok = crc;
    for (int k = 0; k < pre_n; k++)
      put((bad && k == 1) ? 8'h54 : 8'h55, k == 0, nosfd && k == pre_n - 1, 1'b0, g);
    if (!nosfd) begin
      put(8'hD5, pre_n == 0, body_n == 0, err_sfd, g);
      for (int i = 0; i < body_n; i++)
        put((i == 12) ? lt[15:8] : (i == 13) ? lt[7:0] : (8'(i) ^ 8'h3C),
            1'b0, i == body_n - 1, 1'b0, g);
    end
    @(negedge clk);
    got_sv = stat_valid; got_drop = drop; got_stat = stat_word;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
  endtask

  function automatic logic [31:0] expv(input logic [15:0] len, input logic [6:0] f);
    return 32'({1'b1, f[1] | f[2] | f[5], len, f});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [STAT_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'({stat_valid, drop, stat_word}), 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 32'({stat_valid, drop, stat_word}), 32'h0);

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].cfg, int'(VECS[v].pre_n), VECS[v].bad, 1'b0, 1'b0, VECS[v].lt,
           18 + int'(VECS[v].pay), VECS[v].crc, 1'b0);
      check(req_of(VECS[v].flags), 32'({got_sv, got_drop, got_stat}),
            expv(16'(18 + int'(VECS[v].pay)), VECS[v].flags));
    end

    // R10: idle gaps between bytes change nothing
    send(4'b1110, 7, 0, 0, 0, 16'd46, 64, 1, 1);
    check("R10 gaps", 32'({got_sv, got_drop, got_stat}), expv(16'd64, 7'b0000000));

    // R5: frame ends before any delimiter
    send(4'b1110, 5, 0, 0, 1, 16'd0, 0, 1, 0);
    check("R5 no sfd", 32'({got_sv, got_drop, got_stat}), expv(16'd0, 7'b0100000));

    // R3: error on delimiter byte
    send(4'b1010, 7, 0, 1, 0, 16'd46, 64, 1, 0);
    check("R3 err on sfd", 32'({got_sv, got_drop, got_stat}), expv(16'd64, 7'b0000010));

    // R4 with pure check off: long preamble of 20 bytes containing a bad byte
    send(4'b0110, 20, 1, 0, 0, 16'd46, 64, 1, 0);
    check("R4 long only", 32'({got_sv, got_drop, got_stat}), expv(16'd64, 7'b0000100));

    // R11: short frame
    send(4'b1110, 7, 0, 0, 0, 16'd0, 10, 1, 0);
    check("R11 short", 32'({got_sv, got_drop, got_stat}), expv(16'd10, 7'b0001000));
    send(4'b1100, 7, 0, 0, 0, 16'd0, 10, 1, 0);
    check("R11 short no chk", 32'({got_sv, got_drop, got_stat}), expv(16'd10, 7'b0000000));

    // R2: status is a single pulse and the word holds
    held = got_stat;
    repeat (3) @(negedge clk);
    check("R2 hold", 32'({stat_valid, drop, stat_word}), 32'({2'b00, held}));

    // R10: stray bytes outside a frame
    for (int i = 0; i < 5; i++) put(8'h55, 1'b0, i == 4, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 stray", 32'({stat_valid, drop, stat_word}), 32'({2'b00, held}));
    rx_valid = 0; rx_eof = 0;

    // R10: restart discards a broken partial frame
    put(8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    put(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    put(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    send(4'b1110, 7, 0, 0, 0, 16'd46, 64, 1, 0);
    check("R10 restart", 32'({got_sv, got_drop, got_stat}), expv(16'd64, 7'b0000000));

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule